// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block joins two parallel buses, side A and side B, through a pair of holding registers, one for each direction of transfer. Each side's output word comes from a two-way choice. It can pass the opposite bus's incoming word straight through, or it can present the word held in the opposite side's register. Each side also has its own drive enable. The A-to-B enable is active-high and the B-to-A enable is active-low, so the two sides can be driven, isolated or turned around independently. The bus pins appear as separate input, output and output-enable vectors, and the tri-state pads sit outside the block.

Each register loads on a rising transition of its side's capture strobe. The strobe is sampled on the system clock. A register always loads the value its own pin carries at that moment. When the side is not driving, that value is the external input word. When the side is driving, it is the word the block itself puts out. Because of this, one bus word can be copied into both registers, and the two registers can swap their contents in a single clock. A synchronous reset clears both registers and holds both sides non-driving until the first clock edge after reset is released.

Top module: `dual_reg_xcvr`

## Requirements
- R1: `b_oe` is 1 exactly when `ab_drive` is 1, once the power-up window of R3 has ended.
- R2: `a_oe` is 1 exactly when `ba_drive_n` is 0, once the power-up window of R3 has ended.
- R3: While `rst` is 1, and up to the first rising `clk` edge at which `rst` is 0, both `a_oe` and `b_oe` are 0. A `clk` edge with `rst` at 1 clears both registers to all zeros.
- R4: The A register loads the A pin value at a `clk` edge where `a_strobe` is 1 and was 0 at the previous edge. This load does not depend on either enable.
- R5: The B register loads the B pin value at a `clk` edge where `b_strobe` is 1 and was 0 at the previous edge. This load does not depend on either enable.
- R6: A register changes only on a load under R4/R5 or on a reset. A strobe held at 1 loads only once. A strobe that is already 1 when reset is released causes no load until it has been 0.
- R7: `b_out` equals `a_in` without delay when `ab_stored` is 0, and equals the A register when `ab_stored` is 1, whether or not B is driving.
- R8: `a_out` equals `b_in` without delay when `ba_stored` is 0, and equals the B register when `ba_stored` is 1, whether or not A is driving.
- R9: The pin value a register loads is that side's own output word when the side is driving, and its input word otherwise. A pass-through word can therefore be stored into both registers.
- R10: Simultaneous loads on both sides use the values present before the edge. With both sides driving and both stored-selects at 1, the two registers exchange contents.
- R11: With both sides non-driving (`ab_drive`=0, `ba_drive_n`=1), each register still loads its own side's input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every register and strobe sample uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 8 | Word arriving at the A pins from outside |
| b_in | input | 8 | Word arriving at the B pins from outside |
| a_out | output | 8 | Word the block offers to the A pins |
| b_out | output | 8 | Word the block offers to the B pins |
| a_oe | output | 1 | Pad enable for the A pins, 1 = drive |
| b_oe | output | 1 | Pad enable for the B pins, 1 = drive |
| ab_drive | input | 1 | A-to-B direction enable, active-high |
| ba_drive_n | input | 1 | B-to-A direction enable, active-low |
| ab_stored | input | 1 | B output source: 0 = live A input, 1 = A register |
| ba_stored | input | 1 | A output source: 0 = live B input, 1 = B register |
| a_strobe | input | 1 | Capture strobe of the A register (rising transition loads) |
| b_strobe | input | 1 | Capture strobe of the B register (rising transition loads) |

## Verification
The bench builds the block with the default word width of 8. At that width, distinct bit patterns such as 0x3C and 0xC3 make the live word, the A register and the B register easy to tell apart on each output. The setting also makes a swap or a cross-copy visible as a precise exchange of values. The enable and select combinations of the function table, including loads into both registers and simultaneous strobes, all stay within a short directed run.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int unsigned SIDES = 2;
    localparam int unsigned SIDE_A = 0;
    localparam int unsigned SIDE_B = 1;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;

    typedef struct packed {
        logic     drive;
        src_sel_e source;
    } side_ctl_t;

    function automatic int unsigned far_side(input int unsigned s);
        return (s == SIDE_A) ? SIDE_B : SIDE_A;
    endfunction

endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic [WIDTH-1:0] pin_val,
    output logic [WIDTH-1:0] held,
    output logic             load
);
    logic strobe_q;

    assign load = strobe & ~strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b1;
            held     <= '0;
        end else begin
            strobe_q <= strobe;
            if (load) begin
                held <= pin_val;
            end
        end
    end

    // R4 / R5: a detected rising strobe stores the pin value
    a_r4_load_takes_pin: assert property (@(posedge clk) disable iff (rst)
        ($past(load) && !$past(rst)) |-> (held == $past(pin_val)));

    // R6: no load and no reset means the register stays put
    a_r6_hold_without_load: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && !$past(rst)) |-> $stable(held));

endmodule

// File: rtl/xcvr_enable.sv
module xcvr_enable
    import xcvr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SIDES-1:0] req,
    output logic [SIDES-1:0] oe
);
    logic ready_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b0;
        end else begin
            ready_q <= 1'b1;
        end
    end

    assign oe = ready_q ? req : '0;

    // R3: a reset edge leaves both pad enables off for the following cycle
    a_r3_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (oe == '0));

endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  side_ctl_t        ctl,
    input  logic             oe,
    input  logic [WIDTH-1:0] far_live,
    input  logic [WIDTH-1:0] far_held,
    input  logic [WIDTH-1:0] ext_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_seen
);
    always_comb begin
        unique case (ctl.source)
            SRC_STORED: pin_out = far_held;
            default:    pin_out = far_live;
        endcase
    end

    assign pin_seen = oe ? pin_out : ext_in;

endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] b_out,
    output logic             a_oe,
    output logic             b_oe,
    input  logic             ab_drive,
    input  logic             ba_drive_n,
    input  logic             ab_stored,
    input  logic             ba_stored,
    input  logic             a_strobe,
    input  logic             b_strobe
);
    logic      [SIDES-1:0][WIDTH-1:0] ext_in;
    logic      [SIDES-1:0][WIDTH-1:0] pin_out;
    logic      [SIDES-1:0][WIDTH-1:0] pin_seen;
    logic      [SIDES-1:0][WIDTH-1:0] held;
    logic      [SIDES-1:0]            strobe;
    logic      [SIDES-1:0]            load;
    logic      [SIDES-1:0]            req;
    logic      [SIDES-1:0]            oe;
    side_ctl_t [SIDES-1:0]            ctl;

    assign ext_in[SIDE_A] = a_in;
    assign ext_in[SIDE_B] = b_in;
    assign strobe[SIDE_A] = a_strobe;
    assign strobe[SIDE_B] = b_strobe;

    // the B side is fed by the A-to-B path and vice versa
    assign req[SIDE_B] = ab_drive;
    assign req[SIDE_A] = ~ba_drive_n;

    assign ctl[SIDE_A] = '{drive: req[SIDE_A], source: src_sel_e'(ba_stored)};
    assign ctl[SIDE_B] = '{drive: req[SIDE_B], source: src_sel_e'(ab_stored)};

    xcvr_enable u_enable (
        .clk (clk),
        .rst (rst),
        .req (req),
        .oe  (oe)
    );

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        localparam int unsigned FAR = far_side(s);

        xcvr_route #(.WIDTH(WIDTH)) u_route (
            .ctl      (ctl[s]),
            .oe       (oe[s]),
            .far_live (ext_in[FAR]),
            .far_held (held[FAR]),
            .ext_in   (ext_in[s]),
            .pin_out  (pin_out[s]),
            .pin_seen (pin_seen[s])
        );

        xcvr_capture #(.WIDTH(WIDTH)) u_capture (
            .clk     (clk),
            .rst     (rst),
            .strobe  (strobe[s]),
            .pin_val (pin_seen[s]),
            .held    (held[s]),
            .load    (load[s])
        );
    end

    assign a_out = pin_out[SIDE_A];
    assign b_out = pin_out[SIDE_B];
    assign a_oe  = oe[SIDE_A];
    assign b_oe  = oe[SIDE_B];

    // R1: B never drives without the active-high request
    a_r1_b_needs_request: assert property (@(posedge clk) disable iff (rst)
        b_oe |-> ab_drive);

    // R2: A never drives while the active-low request is high
    a_r2_a_needs_request: assert property (@(posedge clk) disable iff (rst)
        a_oe |-> !ba_drive_n);

    // R7: stored selection keeps b_out steady while the A register is idle
    a_r7_stored_b_steady: assert property (@(posedge clk) disable iff (rst)
        (ab_stored && $past(ab_stored) && !$past(load[SIDE_A]) && !$past(rst))
            |-> $stable(b_out));

    // R8: stored selection keeps a_out steady while the B register is idle
    a_r8_stored_a_steady: assert property (@(posedge clk) disable iff (rst)
        (ba_stored && $past(ba_stored) && !$past(load[SIDE_B]) && !$past(rst))
            |-> $stable(a_out));

    // R9: a driving side loading with live selection stores the far input
    a_r9_store_through: assert property (@(posedge clk) disable iff (rst)
        ($past(load[SIDE_B]) && $past(b_oe) && !$past(ab_stored) && !$past(rst))
            |-> (held[SIDE_B] == $past(a_in)));

endmodule

// File: tb/dual_reg_xcvr_tb_top.sv
module dual_reg_xcvr_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] a_out;
    logic [W-1:0] b_out;
    logic         a_oe;
    logic         b_oe;
    logic         ab_drive = 1'b0;
    logic         ba_drive_n = 1'b1;
    logic         ab_stored = 1'b0;
    logic         ba_stored = 1'b0;
    logic         a_strobe = 1'b0;
    logic         b_strobe = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dual_reg_xcvr #(.WIDTH(W)) dut_i (
        .clk(clk), .rst(rst),
        .a_in(a_in), .b_in(b_in),
        .a_out(a_out), .b_out(b_out),
        .a_oe(a_oe), .b_oe(b_oe),
        .ab_drive(ab_drive), .ba_drive_n(ba_drive_n),
        .ab_stored(ab_stored), .ba_stored(ba_stored),
        .a_strobe(a_strobe), .b_strobe(b_strobe)
    );

    typedef struct packed {
        logic         ab_drive;
        logic         ba_drive_n;
        logic         ab_stored;
        logic         ba_stored;
        logic [W-1:0] a_in;
        logic [W-1:0] b_in;
        logic [W-1:0] exp_b;
        logic [W-1:0] exp_a;
        logic         exp_boe;
        logic         exp_aoe;
    } vec_t;

    // applied while A register = 8'h11 and B register = 8'hC3
    localparam vec_t VECS [5] = '{
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'hA5, 8'h5A, 8'hA5, 8'h5A, 1'b1, 1'b0},
        '{1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'hFF, 8'h11, 8'hC3, 1'b0, 1'b1},
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'hF0, 8'h0F, 8'hF0, 8'hC3, 1'b1, 1'b1},
        '{1'b0, 1'b1, 1'b1, 1'b0, 8'h77, 8'h88, 8'h11, 8'h88, 1'b0, 1'b0},
        '{1'b1, 1'b0, 1'b1, 1'b0, 8'h01, 8'h80, 8'h11, 8'h80, 1'b1, 1'b1}
    };

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one rising strobe pair: raise, one edge, lower
    task automatic pulse(input bit pa, input bit pb);
        a_strobe = pa;
        b_strobe = pb;
        @(negedge clk);
        a_strobe = 1'b0;
        b_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(5ns * 20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        // reset with both requests active and A strobe held high
        ab_drive = 1'b1; ba_drive_n = 1'b0;
        ab_stored = 1'b1; ba_stored = 1'b1;
        a_strobe = 1'b1; a_in = 8'h5A;
        cyc(3);
        check("R3 a_oe in reset", W'(a_oe), 0);
        check("R3 b_oe in reset", W'(b_oe), 0);
        check("R3 A register cleared", b_out, 8'h00);
        check("R3 B register cleared", a_out, 8'h00);

        ba_drive_n = 1'b1;
        rst = 1'b0;
        check("R3 b_oe before first edge", W'(b_oe), 0);
        cyc(1);
        check("R1 b_oe after power-up", W'(b_oe), 1);
        check("R2 a_oe off with high request", W'(a_oe), 0);
        cyc(2);
        check("R6 held strobe at reset exit", b_out, 8'h00);
        a_strobe = 1'b0;

        // isolation, simultaneous loads
        ab_drive = 1'b0; ba_drive_n = 1'b1;
        a_in = 8'h3C; b_in = 8'hC3;
        cyc(1);
        check("R11 b_oe isolated", W'(b_oe), 0);
        check("R11 a_oe isolated", W'(a_oe), 0);
        pulse(1'b1, 1'b1);
        check("R4 R11 A register loads a_in", b_out, 8'h3C);
        check("R5 R11 B register loads b_in", a_out, 8'hC3);

        // strobe held high loads once
        a_in = 8'h11; a_strobe = 1'b1;
        cyc(1);
        a_in = 8'h22;
        cyc(3);
        check("R6 held strobe no reload", b_out, 8'h11);
        a_strobe = 1'b0;
        cyc(1);

        // function-table vectors (A reg 11, B reg C3)
        foreach (VECS[i]) begin
            ab_drive = VECS[i].ab_drive; ba_drive_n = VECS[i].ba_drive_n;
            ab_stored = VECS[i].ab_stored; ba_stored = VECS[i].ba_stored;
            a_in = VECS[i].a_in; b_in = VECS[i].b_in;
            cyc(1);
            check($sformatf("R7 b_out vec %0d", i), b_out, VECS[i].exp_b);
            check($sformatf("R8 a_out vec %0d", i), a_out, VECS[i].exp_a);
            check($sformatf("R1 b_oe vec %0d", i), W'(b_oe), W'(VECS[i].exp_boe));
            check($sformatf("R2 a_oe vec %0d", i), W'(a_oe), W'(VECS[i].exp_aoe));
        end

        // A to B pass-through stored into both registers at once
        ab_drive = 1'b1; ba_drive_n = 1'b1; ab_stored = 1'b0; ba_stored = 1'b0;
        a_in = 8'h6B; b_in = 8'h00;
        cyc(1);
        pulse(1'b1, 1'b1);
        ab_stored = 1'b1; ba_stored = 1'b1;
        cyc(1);
        check("R9 B register holds driven A word", a_out, 8'h6B);
        check("R4 A register holds A word", b_out, 8'h6B);

        // B to A pass-through stored into A register
        ab_drive = 1'b0; ba_drive_n = 1'b0; ab_stored = 1'b1; ba_stored = 1'b0;
        b_in = 8'h94; a_in = 8'hFF;
        cyc(1);
        pulse(1'b1, 1'b0);
        check("R9 A register holds driven B word", b_out, 8'h94);

        // both driving, both stored: registers exchange (A=94, B=6B)
        ab_drive = 1'b1; ba_drive_n = 1'b0; ab_stored = 1'b1; ba_stored = 1'b1;
        cyc(1);
        pulse(1'b1, 1'b1);
        check("R10 A register after swap", b_out, 8'h6B);
        check("R10 B register after swap", a_out, 8'h94);

        // reset mid-run
        rst = 1'b1;
        cyc(1);
        check("R3 b_oe during reset", W'(b_oe), 0);
        check("R3 A register cleared again", b_out, 8'h00);
        check("R3 B register cleared again", a_out, 8'h00);
        rst = 1'b0;
        cyc(1);
        check("R2 a_oe after reset", W'(a_oe), 1);

        finished = 1'b1;
        summary();
    end

endmodule